// File: doc/BRIEF.md
# Multi-Area External Bus Chip-Select Controller

This block connects an internal single-beat request port to an 8-bit external memory bus. Each request carries an address, a size (byte, halfword or word), a direction and write data. The controller maps the address onto one of six external areas and drives that area's active-low chip select. It then runs one or more byte cycles with separate active-low read and write strobes.

Each area has its own wait count from 0 to 64. An external active-low wait input can stretch any strobe past that count. A halfword or word request becomes two or four byte cycles at rising addresses, with the lowest byte first (little-endian). Read bytes are packed into the return word, and a one-cycle done pulse ends the request. An address that falls outside every area finishes at once, with an error flag and no bus activity.

A global area-size bit selects between large and small areas. Only the low 16 address bits leave the chip, so each area reaches at most 64 KB of external memory.

Top module: `ebc_bus_ctrl`

## Requirements
- R1: With `small_area_i`=0 each area is 16 MB. The area index is `addr_i[31:24]`, and an index of 0 to 5 selects area n, which drives `ext_cs_no_o[n]` low for the whole access.
- R2: An address whose area index is 6 or more completes one cycle after acceptance, with `done_o`=1 and `err_o`=1. No chip select or strobe is asserted for it.
- R3: Every byte cycle has three phases. Setup lasts 1 cycle, with chip select low and both strobes high. The strobe phase lasts W+1 cycles, where W is the area's wait count. Hold lasts 1 cycle, with chip select low and both strobes high. `ext_addr_o` is constant through all three phases.
- R4: Once the programmed count is used up, each clock edge at which `ext_wait_ni` is low keeps the strobe asserted for one more cycle.
- R5: The `size_i` encoding is 0 for byte (1 cycle), 1 for halfword (2 cycles), and 2 or 3 for word (4 cycles). The byte cycles run back to back, with `ext_addr_o` = `addr_i[15:0]` + i (modulo 2^16) for byte i.
- R6: In write byte cycle i, `ext_wdata_o` carries `wdata_i[8i+7:8i]` and `ext_wdata_oe_o` is high in all three phases. Outside write cycles, `ext_wdata_oe_o` is low and `ext_wdata_o` is 0.
- R7: The byte sampled on `ext_rdata_i` at the last strobe edge of read cycle i is placed in `rdata_o[8i+7:8i]`. Bytes that are not read are 0, and `rdata_o` is valid while `done_o` is high.
- R8: `done_o` is high for exactly the one cycle after the last hold phase, with `err_o`=0. Chip selects are already all high in that cycle.
- R9: The read and write strobes are never low together, and at most one chip select is low at any time.
- R10: A request presented while an access is in progress is ignored.
- R11: The wait count of each area is `wait_cfg_i[7n+6:7n]`, and any value above 64 is treated as 64. The count is sampled when the request is accepted, so later changes do not affect an access already in progress.
- R12: While reset is held and after it is released, all chip selects and strobes are high, and `done_o`, `err_o` and `ext_wdata_oe_o` are low.
- R13: With `small_area_i`=1 each area is 1 MB. The area index is `addr_i[31:20]`, and it is decoded as in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| small_area_i | input | 1 | Area size select: 0 = 16 MB, 1 = 1 MB |
| wait_cfg_i | input | 42 | Per-area wait counts, 7 bits per area |
| req_i | input | 1 | Request strobe, accepted when idle |
| addr_i | input | 32 | Request address |
| size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Assembled read data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Out-of-range flag, valid with done_o |
| ext_cs_no_o | output | 6 | Active-low chip selects |
| ext_addr_o | output | 16 | External address |
| ext_rd_no_o | output | 1 | Active-low read strobe |
| ext_wr_no_o | output | 1 | Active-low write strobe |
| ext_wdata_o | output | 8 | External write data |
| ext_wdata_oe_o | output | 1 | Write data drive enable |
| ext_rdata_i | input | 8 | External read data |
| ext_wait_ni | input | 1 | Active-low wait input |

## Verification
The bench drives these corner cases:
- A zero wait count, which a design with an off-by-one counter would stretch or shorten by one cycle.
- A count of 70, which must be clamped to 64 rather than wrapped or truncated.
- Wait held low past the count, which a design that ignores wait after its counter expires would end too early.
- A word access starting at 0xFFFE, where a design that did not wrap at 16 bits would drive the wrong external addresses.
- Read data delivered in a scrambled byte order, which exposes any design that misplaces or swaps bytes within the return word.
- A second request and a wait-count change arriving in the middle of an access, which a design that re-samples its inputs would act on.
- Out-of-range addresses in both area-size modes, including the boundary index 6. A design that compared only the low index bits would falsely select a chip for these.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } ebc_state_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } ebc_size_e;

  // index of the last byte cycle for a request size
  function automatic logic [1:0] last_beat(input logic [1:0] size);
    case (size)
      SZ_BYTE: last_beat = 2'd0;
      SZ_HALF: last_beat = 2'd1;
      default: last_beat = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/ebc_area_decode.sv
module ebc_area_decode #(
  parameter int NUM_AREAS = 6,
  parameter int ADDR_W    = 32,
  parameter int LG_SHIFT  = 24,
  parameter int SM_SHIFT  = 20,
  parameter int IDX_W     = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              small_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);

  logic [ADDR_W-1:0] hi_lg, hi_sm, hi_sel;

  assign hi_lg  = addr_i >> LG_SHIFT;
  assign hi_sm  = addr_i >> SM_SHIFT;
  assign hi_sel = small_i ? hi_sm : hi_lg;

  // full-width compare: any set upper bit means outside all areas
  assign hit_o = hi_sel < ADDR_W'(NUM_AREAS);
  assign idx_o = hi_sel[IDX_W-1:0];

  always_comb begin
    if (hit_o) assert_idx_range_R1: assert (int'(idx_o) < NUM_AREAS);
  end

endmodule

// File: rtl/ebc_strobe_timer.sv
module ebc_strobe_timer #(
  parameter int WAIT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              run_i,
  input  logic              wait_ni,
  output logic              expire_o
);

  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && (cnt_q == '0) && wait_ni;

  assert_count_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q != '0) |=> run_i);

  assert_wait_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wait_ni) |=> run_i);

endmodule

// File: rtl/ebc_byte_lane.sv
module ebc_byte_lane #(
  parameter int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int LANE_W = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [7:0]        rbyte_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [7:0]        wbyte_o
);

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 byte_q <= '0;
      else if (clr_i)                              byte_q <= '0;
      else if (cap_i && lane_i == LANE_W'(g))      byte_q <= rbyte_i;
    end
    assign rdata_o[8*g +: 8] = byte_q;
  end

  assign wbyte_o = wdata_i[8*lane_i +: 8];

  always_comb begin
    assert_clr_cap_excl_R7: assert (!(clr_i && cap_i));
  end

endmodule

// File: rtl/ebc_bus_ctrl.sv
module ebc_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int NUM_AREAS = 6,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int EXT_AW    = 16,
  parameter int WAIT_W    = 7,
  parameter int MAX_WAIT  = 64,
  parameter int LG_SHIFT  = 24,
  parameter int SM_SHIFT  = 20,
  localparam int IDX_W    = $clog2(NUM_AREAS),
  localparam int BYTES    = DATA_W / 8,
  localparam int LANE_W   = $clog2(BYTES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        small_area_i,
  input  logic [NUM_AREAS*WAIT_W-1:0] wait_cfg_i,
  input  logic                        req_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [1:0]                  size_i,
  input  logic                        we_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        done_o,
  output logic                        err_o,
  output logic [NUM_AREAS-1:0]        ext_cs_no_o,
  output logic [EXT_AW-1:0]           ext_addr_o,
  output logic                        ext_rd_no_o,
  output logic                        ext_wr_no_o,
  output logic [7:0]                  ext_wdata_o,
  output logic                        ext_wdata_oe_o,
  input  logic [7:0]                  ext_rdata_i,
  input  logic                        ext_wait_ni
);

  ebc_state_e state_q;
  logic [IDX_W-1:0]  area_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [EXT_AW-1:0] base_q;
  logic [LANE_W-1:0] beat_q, last_q;
  logic [WAIT_W-1:0] wait_q;
  logic              done_q, err_q;

  logic              dec_hit;
  logic [IDX_W-1:0]  dec_idx;
  logic [WAIT_W-1:0] cfg_arr [NUM_AREAS];
  logic [WAIT_W-1:0] cfg_sel, cfg_clamped;
  logic              accept, busy, strobe_on, expire, lane_clr, lane_cap;
  logic [7:0]        wbyte;

  ebc_area_decode #(
    .NUM_AREAS(NUM_AREAS), .ADDR_W(ADDR_W),
    .LG_SHIFT(LG_SHIFT), .SM_SHIFT(SM_SHIFT), .IDX_W(IDX_W)
  ) i_decode (
    .addr_i (addr_i),
    .small_i(small_area_i),
    .hit_o  (dec_hit),
    .idx_o  (dec_idx)
  );

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cfg
    assign cfg_arr[g] = wait_cfg_i[g*WAIT_W +: WAIT_W];
  end

  assign cfg_sel     = dec_hit ? cfg_arr[dec_idx] : '0;
  assign cfg_clamped = (cfg_sel > WAIT_W'(MAX_WAIT)) ? WAIT_W'(MAX_WAIT) : cfg_sel;

  assign accept    = (state_q == ST_IDLE) && req_i;
  assign busy      = (state_q != ST_IDLE);
  assign strobe_on = (state_q == ST_STROBE);
  assign lane_clr  = accept && dec_hit;
  assign lane_cap  = expire && !we_q;

  ebc_strobe_timer #(.WAIT_W(WAIT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state_q == ST_SETUP),
    .load_val_i(wait_q),
    .run_i     (strobe_on),
    .wait_ni   (ext_wait_ni),
    .expire_o  (expire)
  );

  ebc_byte_lane #(.DATA_W(DATA_W)) i_lane (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (lane_clr),
    .cap_i  (lane_cap),
    .lane_i (beat_q),
    .rbyte_i(ext_rdata_i),
    .wdata_i(wdata_q),
    .rdata_o(rdata_o),
    .wbyte_o(wbyte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      area_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      base_q  <= '0;
      beat_q  <= '0;
      last_q  <= '0;
      wait_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (dec_hit) begin
              state_q <= ST_SETUP;
              area_q  <= dec_idx;
              we_q    <= we_i;
              wdata_q <= wdata_i;
              base_q  <= addr_i[EXT_AW-1:0];
              beat_q  <= '0;
              last_q  <= LANE_W'(last_beat(size_i));
              wait_q  <= cfg_clamped;
            end else begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end
          end
        end
        ST_SETUP:  state_q <= ST_STROBE;
        ST_STROBE: if (expire) state_q <= ST_HOLD;
        ST_HOLD: begin
          if (beat_q == last_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            beat_q  <= beat_q + 1'b1;
            state_q <= ST_SETUP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cs
    assign ext_cs_no_o[g] = !(busy && area_q == IDX_W'(g));
  end

  assign ext_addr_o     = base_q + EXT_AW'(beat_q);
  assign ext_rd_no_o    = !(strobe_on && !we_q);
  assign ext_wr_no_o    = !(strobe_on && we_q);
  assign ext_wdata_oe_o = busy && we_q;
  assign ext_wdata_o    = ext_wdata_oe_o ? wbyte : 8'h00;
  assign done_o         = done_q;
  assign err_o          = err_q;

  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ext_rd_no_o && !ext_wr_no_o));

  assert_one_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ext_cs_no_o));

  assert_strobe_has_cs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_rd_no_o || !ext_wr_no_o) |-> !(&ext_cs_no_o));

  assert_err_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (&ext_cs_no_o && ext_rd_no_o && ext_wr_no_o));

  assert_oe_not_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wdata_oe_o |-> ext_rd_no_o);

  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_cs_no_o[area_q] && busy && $past(busy) && $past(state_q) != ST_HOLD)
      |-> $stable(ext_addr_o));

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (&ext_cs_no_o && !ext_wdata_oe_o));

endmodule

// File: tb/test_ebc_bus_ctrl.sv
module test_ebc_bus_ctrl;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        small_area_i = 1'b0;
  logic [41:0] wait_cfg_i;
  logic        req_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        done_o, err_o;
  logic [5:0]  ext_cs_no_o;
  logic [15:0] ext_addr_o;
  logic        ext_rd_no_o, ext_wr_no_o;
  logic [7:0]  ext_wdata_o;
  logic        ext_wdata_oe_o;
  logic [7:0]  ext_rdata_i = '0;
  logic        ext_wait_ni = 1'b1;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  ebc_bus_ctrl i_ebc_bus_ctrl (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic int wait_of(input int area);
    int v = int'(wait_cfg_i[area*7 +: 7]);
    return (v > 64) ? 64 : v;
  endfunction

  function automatic logic [34:0] observed();
    return {ext_cs_no_o, ext_rd_no_o, ext_wr_no_o, ext_wdata_oe_o, ext_addr_o,
            ext_wdata_oe_o ? ext_wdata_o : 8'h00, done_o, err_o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input logic [34:0] e);
    logic [34:0] o = observed();
    chk(o === e, tag, 64'(o), 64'(e));
    chk(!(!ext_rd_no_o && !ext_wr_no_o) && $onehot0(~ext_cs_no_o), "R9",
        64'({ext_rd_no_o, ext_wr_no_o, ext_cs_no_o}), 64'h0);
  endtask

  // behavioural model of one request, compared every cycle
  task automatic run(input logic [31:0] a, input logic [1:0] sz, input logic w,
                     input logic [31:0] wd, input int extra, input bit poke, input string tag);
    int shift = small_area_i ? 20 : 24;
    logic [31:0] hi = a >> shift;
    bit hit = hi < 32'd6;
    int area = int'(hi[2:0]);
    int beats = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    int wt = hit ? wait_of(area) : 0;
    logic [5:0] cs = ~(6'(1) << area);
    logic [31:0] exp_rd = '0;
    @(negedge clk_i);
    req_i = 1'b1; addr_i = a; size_i = sz; we_i = w; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
    if (!hit) begin
      cyc("R2", {6'h3F, 1'b1, 1'b1, 1'b0, 16'(ext_addr_o), 8'h00, 1'b1, 1'b1});
      @(negedge clk_i);
      chk(done_o === 1'b0 && &ext_cs_no_o, "R2", 64'({done_o, ext_cs_no_o}), 64'h3F);
      return;
    end
    for (int b = 0; b < beats; b++) begin
      logic [15:0] ea = a[15:0] + 16'(b);
      logic [7:0] wb = w ? wd[8*b +: 8] : 8'h00;
      cyc(tag, {cs, 1'b1, 1'b1, w, ea, wb, 1'b0, 1'b0});
      @(negedge clk_i);
      for (int k = 1; k <= wt + 1 + extra; k++) begin
        cyc((extra > 0 && k > wt + 1) ? "R4" : tag, {cs, w, !w, w, ea, wb, 1'b0, 1'b0});
        if (poke && b == 0 && k == 1) begin
          req_i = 1'b1; addr_i = 32'h0100_0000; we_i = 1'b0;
          wait_cfg_i[area*7 +: 7] = 7'd9;
        end else begin
          req_i = 1'b0;
        end
        ext_wait_ni = (extra > 0 && k <= wt + extra) ? 1'b0 : 1'b1;
        ext_rdata_i = mem_byte(ea);
        @(negedge clk_i);
      end
      req_i = 1'b0;
      ext_wait_ni = 1'b1;
      exp_rd[8*b +: 8] = mem_byte(ea);
      cyc(tag, {cs, 1'b1, 1'b1, w, ea, wb, 1'b0, 1'b0});
      @(negedge clk_i);
    end
    chk(done_o === 1'b1 && err_o === 1'b0 && &ext_cs_no_o, "R8",
        64'({done_o, err_o, ext_cs_no_o}), 64'({1'b1, 1'b0, 6'h3F}));
    if (!w) chk(rdata_o === exp_rd, "R7", 64'(rdata_o), 64'(exp_rd));
    @(negedge clk_i);
    chk(done_o === 1'b0 && &ext_cs_no_o && ext_rd_no_o && ext_wr_no_o,
        poke ? "R10" : "R8", 64'({done_o, ext_cs_no_o}), 64'h3F);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // areas: 0:0 1:1 2:3 3:2 4:70 5:5
    wait_cfg_i = {7'd5, 7'd70, 7'd2, 7'd3, 7'd1, 7'd0};
    #35;
    chk(&ext_cs_no_o && ext_rd_no_o && ext_wr_no_o && !done_o && !err_o && !ext_wdata_oe_o,
        "R12", 64'(observed()), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(&ext_cs_no_o && ext_rd_no_o && ext_wr_no_o && !done_o && !err_o && !ext_wdata_oe_o,
        "R12", 64'(observed()), 64'h0);

    run(32'h0000_1234, 2'd0, 1'b0, 32'h0, 0, 0, "R1");
    run(32'h0100_00F0, 2'd0, 1'b1, 32'h0000_00C3, 0, 0, "R6");
    run(32'h0200_4000, 2'd1, 1'b0, 32'h0, 0, 0, "R5");
    run(32'h0300_0101, 2'd2, 1'b1, 32'hDEAD_BEEF, 3, 0, "R6");
    run(32'h0505_FFFE, 2'd2, 1'b0, 32'h0, 0, 0, "R5");
    run(32'h0402_0010, 2'd3, 1'b0, 32'h0, 2, 0, "R4");
    run(32'h0400_0008, 2'd0, 1'b0, 32'h0, 0, 0, "R11");
    run(32'h0100_0200, 2'd2, 1'b1, 32'h1122_3344, 0, 1, "R10");
    wait_cfg_i[1*7 +: 7] = 7'd1;
    run(32'h0200_0300, 2'd0, 1'b0, 32'h0, 0, 1, "R11");
    wait_cfg_i[2*7 +: 7] = 7'd3;

    small_area_i = 1'b1;
    run(32'h0030_0012, 2'd2, 1'b0, 32'h0, 0, 0, "R13");
    run(32'h0050_8000, 2'd1, 1'b1, 32'h0000_A55A, 1, 0, "R13");
    run(32'h0060_0000, 2'd0, 1'b0, 32'h0, 0, 0, "R13");
    run(32'h0100_0000, 2'd0, 1'b0, 32'h0, 0, 0, "R13");
    small_area_i = 1'b0;
    run(32'h0030_0012, 2'd0, 1'b0, 32'h0, 0, 0, "R13");

    run(32'h0600_0000, 2'd0, 1'b0, 32'h0, 0, 0, "R2");
    run(32'hF000_0003, 2'd2, 1'b1, 32'h0, 0, 0, "R2");
    run(32'h05FF_FFFF, 2'd0, 1'b1, 32'h0000_0077, 0, 0, "R3");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule